// File: doc/BRIEF.md
# Threadblock Dispatcher with Shared-Resource Admission

This block sits inside one shader core. It takes threadblock descriptors from the upper-level scheduler into a short waitlist. Each descriptor carries a kernel number, a warp count, a scratchpad size in bytes, a register count per warp and an urgency flag. Every cycle the dispatcher looks at the block it is working on. That is either the block whose warps are already being handed out, or the waitlist head. The dispatcher checks that block against three resources: the shared scratchpad pool, the per-SM register budget, and the per-SM convergence-stack slots. When everything fits, it offers one warp to an SM.

Descriptors arrive on a valid/ready stream. `in_ready` is low while the waitlist is full, and a descriptor is taken on a cycle where `in_valid` and `in_ready` are both high. Warps leave on a second valid/ready stream. `disp_valid` is a combinational offer made from registered state, and the warp is handed over only on a cycle where `disp_ready` is also high. While `disp_ready` is low, the offer is held and nothing is reserved. Completion pulses from the SMs return the resources. An urgent descriptor overtakes the waiting ones, which gives time sharing at threadblock granularity. Several kernels may have warps resident on one SM at the same time.

Top module: `block_launcher`

## Requirements
- R1: `in_ready` is high exactly when the waitlist holds fewer than DEPTH (default 4) descriptors. A descriptor is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R2: A taken descriptor is rejected if it has scratchpad bytes above 32768, a warp count of 0, or registers per warp above REGS_PER_SM (default 256). A rejected descriptor is never queued or dispatched, and `in_err` is high for exactly the cycle after the handshake. A request of exactly 32768 bytes is accepted.
- R3: A queued block may start only when a block tag is free and its scratchpad bytes plus the bytes already reserved are at most 65536. Otherwise no warp is offered and the block waits at the head.
- R4: A warp needs one free convergence-stack slot (SLOTS, default 8, per SM) and free registers at least equal to its registers per warp. It is offered to the lowest-numbered SM that has both. If no SM has both, `disp_valid` is low.
- R5: At most one warp is handed over per cycle, on a cycle where `disp_valid` and `disp_ready` are both high. While `disp_ready` is low, nothing is reserved.
- R6: All warps of a started block are offered one after another before any other block. Among queued descriptors, an urgent one is placed ahead of all others (the most recent urgent one comes first), and a normal one is placed behind all others. `disp_kid` carries the kernel number of the block being served.
- R7: A completion pulse (`done_valid`, with `done_sm` and `done_tag`) returns one slot and the block's registers per warp to that SM. They are usable from the next cycle.
- R8: A block's scratchpad bytes are reserved when its first warp is handed over and released when its last warp completes; its tag is freed at the same time. A starting block takes the lowest-numbered free tag, and `disp_tag` carries the block's tag.
- R9: After reset, `in_ready` is 1, `disp_valid` is 0, `in_err` is 0, every SM is fully free and no scratchpad is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Waitlist has room |
| in_kid | input | KID_W | Kernel number |
| in_warps | input | WARP_W | Warp count of the block |
| in_spad | input | SPAD_W | Scratchpad bytes for the block |
| in_regs | input | REG_W | Registers per warp |
| in_prio | input | 1 | Urgent descriptor, goes to the front |
| in_err | output | 1 | One-cycle pulse: last taken descriptor was rejected |
| disp_valid | output | 1 | A warp is offered |
| disp_ready | input | 1 | SM side accepts the offered warp |
| disp_sm | output | log2(NSM) | Target SM |
| disp_kid | output | KID_W | Kernel number of the warp |
| disp_tag | output | log2(NBLK) | Resident block tag of the warp |
| done_valid | input | 1 | A warp completed |
| done_sm | input | log2(NSM) | SM of the completed warp |
| done_tag | input | log2(NBLK) | Block tag of the completed warp |

## Verification
The dispatch offer is combinational from registered state. The bench therefore samples `disp_valid`, `disp_sm`, `disp_kid` and `disp_tag` at the falling edge and compares them with a model state updated for the edge before. `in_err` is due one rising edge after the handshake. Resources returned by a completion or freed by a handshake show up in the offer one edge later. `in_ready` reflects the waitlist fill after the last edge. Inputs are driven at the falling edge right after each comparison, and the model is advanced with those same inputs, so every expected value lines up with its cycle.

// File: rtl/blk_pkg.sv
package blk_pkg;
  parameter int KID_W  = 4;
  parameter int WARP_W = 4;
  parameter int SPAD_W = 17;
  parameter int REG_W  = 9;

  typedef struct packed {
    logic [KID_W-1:0]  kid;
    logic [WARP_W-1:0] warps;
    logic [SPAD_W-1:0] spad;
    logic [REG_W-1:0]  regs;
  } blk_desc_t;
endpackage

// File: rtl/blk_waitlist.sv
module blk_waitlist import blk_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      front,
  input  logic      pop,
  input  blk_desc_t din,
  output logic      full,
  output logic      nonempty,
  output blk_desc_t head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  blk_desc_t       mem [DEPTH];
  logic [PW-1:0]   hd, tl;
  logic [CW-1:0]   cnt;

  assign head     = mem[hd];
  assign full     = (cnt == CW'(DEPTH));
  assign nonempty = (cnt != '0);

  always_ff @(posedge clk) begin
    if (push) begin
      if (!front)   mem[tl]          <= din;
      else if (pop) mem[hd]          <= din;
      else          mem[hd - PW'(1)] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
    end else begin
      if (push && front && !pop)        hd <= hd - PW'(1);
      else if (pop && !(push && front)) hd <= hd + PW'(1);
      if (push && !front)               tl <= tl + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> nonempty);
endmodule

// File: rtl/sm_ledger.sv
module sm_ledger import blk_pkg::*; #(
  parameter int SLOTS       = 8,
  parameter int REGS_PER_SM = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] need_regs,
  input  logic             take,
  input  logic             give,
  input  logic [REG_W-1:0] give_regs,
  output logic             fits
);
  localparam int SW = $clog2(SLOTS + 1);
  localparam int RW = (REG_W > $clog2(REGS_PER_SM + 1)) ? REG_W : $clog2(REGS_PER_SM + 1);

  logic [SW-1:0] slots;
  logic [RW-1:0] regs_free;
  logic [RW-1:0] need_w, give_w;

  assign need_w = RW'(need_regs);
  assign give_w = RW'(give_regs);
  assign fits   = (slots != '0) && (regs_free >= need_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots     <= SW'(SLOTS);
      regs_free <= RW'(REGS_PER_SM);
    end else begin
      slots     <= slots - SW'(take) + SW'(give);
      regs_free <= regs_free - (take ? need_w : '0) + (give ? give_w : '0);
    end
  end

  // R4
  take_fit_chk: assert property (@(posedge clk) disable iff (!rst_n) take |-> fits);
  // R7
  slot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slots <= SW'(SLOTS)) && (regs_free <= RW'(REGS_PER_SM)));
endmodule

// File: rtl/sm_pick.sv
module sm_pick #(
  parameter int NSM = 4
) (
  input  logic [NSM-1:0]                   fit,
  output logic                             any,
  output logic [((NSM>1)?$clog2(NSM):1)-1:0] idx
);
  localparam int SMW = (NSM > 1) ? $clog2(NSM) : 1;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int s = NSM - 1; s >= 0; s--) begin
      if (fit[s]) begin
        any = 1'b1;
        idx = SMW'(s);
      end
    end
  end
endmodule

// File: rtl/block_launcher.sv
module block_launcher import blk_pkg::*; #(
  parameter int NSM          = 4,
  parameter int SLOTS        = 8,
  parameter int REGS_PER_SM  = 256,
  parameter int SPAD_TOTAL   = 65536,
  parameter int SPAD_BLK_MAX = 32768,
  parameter int NBLK         = 4,
  parameter int DEPTH        = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [KID_W-1:0]                    in_kid,
  input  logic [WARP_W-1:0]                   in_warps,
  input  logic [SPAD_W-1:0]                   in_spad,
  input  logic [REG_W-1:0]                    in_regs,
  input  logic                                in_prio,
  output logic                                in_err,
  output logic                                disp_valid,
  input  logic                                disp_ready,
  output logic [((NSM>1)?$clog2(NSM):1)-1:0]   disp_sm,
  output logic [KID_W-1:0]                    disp_kid,
  output logic [((NBLK>1)?$clog2(NBLK):1)-1:0] disp_tag,
  input  logic                                done_valid,
  input  logic [((NSM>1)?$clog2(NSM):1)-1:0]   done_sm,
  input  logic [((NBLK>1)?$clog2(NBLK):1)-1:0] done_tag
);
  localparam int SMW  = (NSM > 1) ? $clog2(NSM) : 1;
  localparam int TAGW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam logic [SPAD_W:0]   TOT_V = (SPAD_W+1)'(SPAD_TOTAL);
  localparam logic [SPAD_W-1:0] MAX_V = SPAD_W'(SPAD_BLK_MAX);
  localparam logic [REG_W-1:0]  RMAX  = REG_W'(REGS_PER_SM);

  // intake
  logic      full, head_v, bad, in_fire, push, pop;
  blk_desc_t in_d, head_d;

  assign in_d     = '{kid: in_kid, warps: in_warps, spad: in_spad, regs: in_regs};
  assign in_ready = !full;
  assign in_fire  = in_valid && in_ready;
  assign bad      = (in_spad > MAX_V) || (in_warps == '0) || (in_regs > RMAX);
  assign push     = in_fire && !bad;

  blk_waitlist #(.DEPTH(DEPTH)) u_wait (
    .clk(clk), .rst_n(rst_n), .push(push), .front(in_prio), .pop(pop),
    .din(in_d), .full(full), .nonempty(head_v), .head(head_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_err <= 1'b0;
    else        in_err <= in_fire && bad;
  end

  // block in progress
  logic              cur_v;
  blk_desc_t         cur_d, src_d;
  logic [TAGW-1:0]   cur_tag, free_tag;
  logic [WARP_W-1:0] cur_left;

  // resident block table
  logic [NBLK-1:0]   busy;
  logic [WARP_W-1:0] blk_out  [NBLK];
  logic [SPAD_W-1:0] blk_spad [NBLK];
  logic [REG_W-1:0]  blk_regs [NBLK];
  logic [SPAD_W-1:0] spad_used;
  logic              tag_any, spad_ok, can_start, fire, start, last;

  always_comb begin
    tag_any  = 1'b0;
    free_tag = '0;
    for (int t = NBLK - 1; t >= 0; t--) begin
      if (!busy[t]) begin
        tag_any  = 1'b1;
        free_tag = TAGW'(t);
      end
    end
  end

  assign spad_ok   = ({1'b0, spad_used} + {1'b0, head_d.spad}) <= TOT_V;
  assign can_start = !cur_v && head_v && tag_any && spad_ok;
  assign src_d     = cur_v ? cur_d : head_d;

  // per-SM accounting
  logic [NSM-1:0] fit, take, give;
  logic           pick_any;
  logic [SMW-1:0] pick_idx;

  for (genvar s = 0; s < NSM; s++) begin : g_sm
    assign take[s] = fire && (disp_sm == SMW'(s));
    assign give[s] = done_valid && (done_sm == SMW'(s));
    sm_ledger #(.SLOTS(SLOTS), .REGS_PER_SM(REGS_PER_SM)) u_led (
      .clk(clk), .rst_n(rst_n), .need_regs(src_d.regs), .take(take[s]),
      .give(give[s]), .give_regs(blk_regs[done_tag]), .fits(fit[s])
    );
  end

  sm_pick #(.NSM(NSM)) u_pick (.fit(fit), .any(pick_any), .idx(pick_idx));

  assign disp_valid = (cur_v || can_start) && pick_any;
  assign disp_sm    = pick_idx;
  assign disp_kid   = src_d.kid;
  assign disp_tag   = cur_v ? cur_tag : free_tag;
  assign fire       = disp_valid && disp_ready;
  assign start      = fire && !cur_v;
  assign pop        = start;
  assign last       = done_valid && (blk_out[done_tag] == WARP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v    <= 1'b0;
      cur_d    <= '0;
      cur_tag  <= '0;
      cur_left <= '0;
    end else if (start) begin
      cur_v    <= (head_d.warps > WARP_W'(1));
      cur_d    <= head_d;
      cur_tag  <= free_tag;
      cur_left <= head_d.warps - WARP_W'(1);
    end else if (fire) begin
      cur_left <= cur_left - WARP_W'(1);
      if (cur_left == WARP_W'(1)) cur_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= '0;
      spad_used <= '0;
      for (int t = 0; t < NBLK; t++) begin
        blk_out[t]  <= '0;
        blk_spad[t] <= '0;
        blk_regs[t] <= '0;
      end
    end else begin
      spad_used <= spad_used + (start ? head_d.spad : '0) - (last ? blk_spad[done_tag] : '0);
      for (int t = 0; t < NBLK; t++) begin
        if (start && free_tag == TAGW'(t)) begin
          busy[t]     <= 1'b1;
          blk_out[t]  <= head_d.warps;
          blk_spad[t] <= head_d.spad;
          blk_regs[t] <= head_d.regs;
        end else if (done_valid && done_tag == TAGW'(t)) begin
          blk_out[t] <= blk_out[t] - WARP_W'(1);
          if (blk_out[t] == WARP_W'(1)) busy[t] <= 1'b0;
        end
      end
    end
  end

  // R5
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(take));
  // R3
  spad_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, spad_used} <= TOT_V);
  // R2
  bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n) (in_fire && bad) |=> in_err);
  // R8
  done_live_chk: assert property (@(posedge clk) disable iff (!rst_n) done_valid |-> busy[done_tag]);
  // R6
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v && !fire) |=> (cur_v && $stable(cur_tag)));
endmodule

// File: tb/block_launcher_tb.sv
`timescale 1ns/1ps
module block_launcher_tb_top;
  import blk_pkg::*;
  localparam int NSM = 4, SLOTS = 8, RPS = 256, NBLK = 4, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_prio = 0, disp_ready = 0, done_valid = 0;
  logic [KID_W-1:0] in_kid = '0;
  logic [WARP_W-1:0] in_warps = '0;
  logic [SPAD_W-1:0] in_spad = '0;
  logic [REG_W-1:0] in_regs = '0;
  logic [1:0] done_sm = '0, done_tag = '0;
  logic in_ready, in_err, disp_valid;
  logic [1:0] disp_sm, disp_tag;
  logic [KID_W-1:0] disp_kid;

  always #10 clk = ~clk;

  block_launcher dut_i (.*);

  int checks = 0, fails = 0;
  // model state
  int m_slots[NSM], m_fregs[NSM], m_out[NBLK], m_spad[NBLK], m_regs[NBLK];
  bit m_busy[NBLK];
  int m_used, m_cur_tag, m_cur_left;
  bit m_cur_v, m_err;
  blk_desc_t m_cur;
  blk_desc_t mq[$];
  int pend_sm[$], pend_tag[$];
  bit ev; int esm, etag, ekid; blk_desc_t esrc;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic blk_desc_t mk(int k, int w, int s, int r);
    blk_desc_t d;
    d.kid = KID_W'(k); d.warps = WARP_W'(w); d.spad = SPAD_W'(s); d.regs = REG_W'(r);
    return d;
  endfunction

  task automatic calc();
    bit src_ok;
    int ft;
    ev = 0; esm = 0; etag = 0; ekid = 0; src_ok = 0; ft = -1;
    for (int t = NBLK - 1; t >= 0; t--) if (!m_busy[t]) ft = t;
    if (m_cur_v) begin
      esrc = m_cur; src_ok = 1; etag = m_cur_tag;
    end else if (mq.size() > 0) begin
      esrc = mq[0];
      src_ok = (ft >= 0) && (m_used + int'(esrc.spad) <= 65536);
      etag = ft;
    end
    if (src_ok)
      for (int s = NSM - 1; s >= 0; s--)
        if (m_slots[s] > 0 && m_fregs[s] >= int'(esrc.regs)) begin ev = 1; esm = s; end
    ekid = int'(esrc.kid);
  endtask

  task automatic step(bit iv, blk_desc_t d, bit pr, bit dr, bit dv, int dsm, int dtg);
    bit acc, isbad, fire;
    calc();
    chk(in_ready === (mq.size() < DEPTH), "R1", "in_ready", in_ready, mq.size() < DEPTH);
    chk(in_err === m_err, "R2", "in_err", in_err, m_err);
    chk(disp_valid === ev, "R3 R4 R5 R7", "disp_valid", disp_valid, ev);
    if (ev && disp_valid) begin
      chk(int'(disp_sm) == esm, "R4", "disp_sm", disp_sm, esm);
      chk(int'(disp_kid) == ekid, "R6", "disp_kid", disp_kid, ekid);
      chk(int'(disp_tag) == etag, "R8", "disp_tag", disp_tag, etag);
    end
    in_valid = iv; in_kid = d.kid; in_warps = d.warps; in_spad = d.spad; in_regs = d.regs;
    in_prio = pr; disp_ready = dr; done_valid = dv; done_sm = 2'(dsm); done_tag = 2'(dtg);
    acc = iv && (mq.size() < DEPTH);
    isbad = (int'(d.spad) > 32768) || (d.warps == 0) || (int'(d.regs) > RPS);
    fire = ev && dr;
    if (fire) begin
      if (!m_cur_v) begin
        m_busy[etag] = 1; m_out[etag] = int'(esrc.warps);
        m_spad[etag] = int'(esrc.spad); m_regs[etag] = int'(esrc.regs);
        m_used += int'(esrc.spad);
        void'(mq.pop_front());
        if (esrc.warps > 1) begin
          m_cur_v = 1; m_cur = esrc; m_cur_tag = etag; m_cur_left = int'(esrc.warps) - 1;
        end
      end else begin
        m_cur_left--;
        if (m_cur_left == 0) m_cur_v = 0;
      end
      m_slots[esm]--; m_fregs[esm] -= int'(esrc.regs);
      pend_sm.push_back(esm); pend_tag.push_back(etag);
    end
    if (dv) begin
      m_slots[dsm]++; m_fregs[dsm] += m_regs[dtg];
      m_out[dtg]--;
      if (m_out[dtg] == 0) begin m_busy[dtg] = 0; m_used -= m_spad[dtg]; end
    end
    if (acc && !isbad) begin
      if (pr) mq.push_front(d); else mq.push_back(d);
    end
    m_err = acc && isbad;
    @(negedge clk);
  endtask

  task automatic rstep(bit allow_in, int dr_pct, int done_pct);
    blk_desc_t d;
    int sel, idx, dsm, dtg;
    bit dv;
    sel = $urandom_range(0, 9);
    d = mk($urandom_range(0, 15), ($urandom_range(0, 19) == 0) ? 0 : $urandom_range(1, 6),
           (sel == 0) ? 32768 : (sel == 1) ? 32769 : $urandom_range(0, 30000),
           ($urandom_range(0, 19) == 0) ? 257 : $urandom_range(8, 128));
    dv = 0; dsm = 0; dtg = 0;
    if (pend_sm.size() > 0 && $urandom_range(0, 99) < done_pct) begin
      idx = $urandom_range(0, pend_sm.size() - 1);
      dv = 1; dsm = pend_sm[idx]; dtg = pend_tag[idx];
      pend_sm.delete(idx); pend_tag.delete(idx);
    end
    step(allow_in && ($urandom_range(0, 2) != 0), d, $urandom_range(0, 3) == 0,
         $urandom_range(0, 99) < dr_pct, dv, dsm, dtg);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240813));
    for (int s = 0; s < NSM; s++) begin m_slots[s] = SLOTS; m_fregs[s] = RPS; end
    for (int t = 0; t < NBLK; t++) begin m_busy[t] = 0; m_out[t] = 0; m_spad[t] = 0; m_regs[t] = 0; end
    m_used = 0; m_cur_v = 0; m_err = 0; m_cur_tag = 0; m_cur_left = 0; m_cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(in_ready === 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(disp_valid === 1'b0, "R9", "disp_valid after reset", disp_valid, 0);
    chk(in_err === 1'b0, "R9", "in_err after reset", in_err, 0);
    // R1: fill waitlist while SM side stalls (R5), fifth is refused
    for (int i = 0; i < 5; i++) step(1, mk(i, 2, 4096, 16), 0, 0, 0, 0, 0);
    // R6: urgent descriptor overtakes queued ones
    repeat (3) step(0, mk(0, 1, 0, 8), 0, 1, 0, 0, 0);
    step(1, mk(9, 1, 1024, 8), 1, 1, 0, 0, 0);
    repeat (40) rstep(0, 100, 70);
    // R3: two 32 KB blocks fill the pool, third waits
    step(1, mk(1, 1, 32768, 8), 0, 1, 0, 0, 0);
    step(1, mk(2, 1, 32768, 8), 0, 1, 0, 0, 0);
    step(1, mk(3, 1, 16, 8), 0, 1, 0, 0, 0);
    repeat (6) step(0, mk(0, 1, 0, 8), 0, 1, 0, 0, 0);
    repeat (30) rstep(0, 100, 70);
    // R2: oversized, zero-warp and register-hungry descriptors are rejected
    step(1, mk(4, 1, 32769, 8), 0, 1, 0, 0, 0);
    step(1, mk(5, 0, 16, 8), 0, 1, 0, 0, 0);
    step(1, mk(6, 1, 16, 257), 0, 1, 0, 0, 0);
    step(1, mk(7, 1, 32768, 256), 0, 1, 0, 0, 0);
    repeat (30) rstep(0, 100, 70);
    // R4 R7: heavy warps, one per SM until completions return registers
    step(1, mk(8, 6, 0, 200), 0, 1, 0, 0, 0);
    repeat (8) step(0, mk(0, 1, 0, 8), 0, 1, 0, 0, 0);
    repeat (40) rstep(0, 100, 70);
    // random mix
    repeat (4000) rstep(1, 80, 45);
    repeat (100) rstep(0, 100, 80);
    summary();
    $finish;
  end
endmodule